// File: doc/BRIEF.md
# Priority Interrupt Controller

This block collects up to 128 level-sensitive interrupt sources and presents a single interrupt request to a processor. Software controls it over a simple 32-bit register bus. Every source has a mask bit, and the mask bits are grouped into 32-line banks. Each bank is changed through a write-one-to-set port and a write-one-to-clear port, so masking one line never needs a read-modify-write. Each bank also exposes its live pending word. Every source has its own priority register.

A combinational arbiter looks at all unmasked, active sources and picks the one with the smallest priority value. When no interrupt is held, the winner is captured into a sorted register and the request output rises. The captured line stays there until software writes an acknowledge. After that, the next arbitration result may be captured.

A soft reset started from a configuration register returns all state to its reset values over a fixed number of cycles. A status bit shows when the soft reset has completed.

Top module: `irqc_top`

## Requirements
- R1: After reset the following hold. All mask bits read 1. Every priority register reads 0. The sorted register (0x40) reads 0xFF, meaning bit 7 is the spurious flag and bits 6:0 are 0x7F. irq_o is low. Status bit 0 (0x14) reads 1.
- R2: Offset 0x00 reads the 8-bit revision parameter (major version in bits 7:4, minor version in bits 3:0), zero-extended to 32 bits.
- R3: A write to the mask-set port of bank b (0x8C + 0x20*b) sets every mask bit whose data bit is 1. Zero data bits leave the mask unchanged. The bank's mask reads at 0x84 + 0x20*b.
- R4: A write to the mask-clear port of bank b (0x88 + 0x20*b) clears every mask bit whose data bit is 1.
- R5: The pending word of bank b (0x98 + 0x20*b) equals the source bits ANDed with the inverted mask bits. It follows the sources in the same cycle and drops as soon as a source deasserts.
- R6: Line i has a priority register at 0x100 + 4*i holding PRIO_W bits. It reads back what was written.
- R7: Arbitration selects the pending line with the numerically lowest priority. On a tie, the lower line number wins.
- R8: When no interrupt is held and any line is pending, the winner is captured at the next clock edge and irq_o goes high from that edge. While held, the sorted register reads {bit7=0, line} and stays unchanged even if sources or masks change.
- R9: A write to 0x48 with bit 0 set releases the held interrupt, and irq_o is low in the following cycle. A write to 0x48 with bit 0 clear has no effect.
- R10: A write to 0x10 with bit 1 set starts a soft reset. For the write cycle plus RST_CYC further cycles, all state is forced to its R1 values and register writes are ignored. During the RST_CYC cycles, 0x10 bit 1 reads 1 and 0x14 bit 0 reads 0. Afterwards 0x14 bit 0 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_LINES | Level-sensitive interrupt sources |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 10 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupted mask bit appears on the pending word of its bank in the same cycle, and on irq_o at the next edge if that line is the only candidate. A wrong priority or a wrong tie-break appears as the wrong line number in the sorted register one cycle after an acknowledge. A lost or stuck held flag shows up on irq_o within one clock, because irq_o is compared on every clock against a behavioural model. A soft-reset counter of the wrong length appears as status bit 0 changing a cycle early or late, and as writes being accepted or dropped at the boundary.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned LINE_W     = 7;
  localparam int unsigned BANK_LINES = 32;
  localparam int unsigned MAX_BANKS  = 4;
  localparam int unsigned ADDR_W     = 10;

  localparam logic [ADDR_W-1:0] OFF_REV  = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_STAT = 10'h014;
  localparam logic [ADDR_W-1:0] OFF_SORT = 10'h040;
  localparam logic [ADDR_W-1:0] OFF_ACK  = 10'h048;

  // per-bank sub-offsets inside a 0x20 stride starting at 0x80
  localparam logic [4:0] BOFF_MASK = 5'h04;
  localparam logic [4:0] BOFF_CLR  = 5'h08;
  localparam logic [4:0] BOFF_SET  = 5'h0C;
  localparam logic [4:0] BOFF_PEND = 5'h18;

  typedef struct packed {
    logic              valid;
    logic [LINE_W-1:0] line;
  } win_t;
endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wipe_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '1;
    else if (wipe_i) mask_q <= '1;
    else if (set_i)  mask_q <= mask_q | data_i;
    else if (clr_i)  mask_q <= mask_q & ~data_i;
  end

  assign mask_o = mask_q;
  assign pend_o = src_i & ~mask_q;
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 128,
  parameter int unsigned PRIO_W    = 6
) (
  input  logic [NUM_LINES-1:0]        pend_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  output win_t                        win_o
);
  logic [PRIO_W-1:0] best;

  // strict less-than keeps the lower index on ties
  always_comb begin
    win_o = '0;
    best  = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pend_i[i] && (!win_o.valid || prio_i[i*PRIO_W +: PRIO_W] < best)) begin
        win_o.valid = 1'b1;
        win_o.line  = LINE_W'(i);
        best        = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irqc_soft_rst.sv
module irqc_soft_rst #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic wipe_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    else if (start_i)     cnt_q <= CNT_W'(CYCLES);
  end

  assign busy_o = (cnt_q != '0);
  assign wipe_o = busy_o | start_i;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 128,
  parameter int unsigned PRIO_W    = 6,
  parameter int unsigned RST_CYC   = 4,
  parameter logic [7:0]  REV       = 8'h21
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] src_i,
  input  logic                 bus_en_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic                 irq_o
);
  localparam int unsigned NUM_BANKS = NUM_LINES / BANK_LINES;

  logic                 wr, soft_start, busy, wipe, ack;
  logic                 bank_hit, prio_ok;
  logic [1:0]           bank_sel;
  logic [4:0]           bank_off;
  logic [7:0]           prio_idx;
  logic [NUM_LINES-1:0] mask_all, pend_all;
  logic [31:0]          mask_w [MAX_BANKS];
  logic [31:0]          pend_w [MAX_BANKS];
  logic [PRIO_W-1:0]    prio_q [NUM_LINES];
  logic [NUM_LINES*PRIO_W-1:0] prio_flat;
  win_t                 win;
  logic                 held_q;
  logic [LINE_W-1:0]    line_q;

  // address decode
  assign wr         = bus_en_i & bus_we_i;
  assign soft_start = wr && bus_addr_i == OFF_CFG && bus_wdata_i[1];
  assign ack        = wr && bus_addr_i == OFF_ACK && bus_wdata_i[0];
  assign bank_hit   = bus_addr_i[9:7] == 3'b001;
  assign bank_sel   = bus_addr_i[6:5];
  assign bank_off   = bus_addr_i[4:0];
  assign prio_idx   = bus_addr_i[9:2] - 8'd64;
  assign prio_ok    = (bus_addr_i[9:8] != 2'b00) && (bus_addr_i[1:0] == 2'b00)
                      && (prio_idx < 8'(NUM_LINES));

  irqc_soft_rst #(.CYCLES(RST_CYC)) u_srst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (soft_start),
    .busy_o  (busy),
    .wipe_o  (wipe)
  );

  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
    if (b < NUM_BANKS) begin : g_on
      irqc_mask_bank #(.WIDTH(BANK_LINES)) u_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wipe_i (wipe),
        .set_i  (wr && bank_hit && bank_sel == 2'(b) && bank_off == BOFF_SET),
        .clr_i  (wr && bank_hit && bank_sel == 2'(b) && bank_off == BOFF_CLR),
        .data_i (bus_wdata_i),
        .src_i  (src_i[b*BANK_LINES +: BANK_LINES]),
        .mask_o (mask_all[b*BANK_LINES +: BANK_LINES]),
        .pend_o (pend_all[b*BANK_LINES +: BANK_LINES])
      );
      assign mask_w[b] = mask_all[b*BANK_LINES +: BANK_LINES];
      assign pend_w[b] = pend_all[b*BANK_LINES +: BANK_LINES];
    end else begin : g_off
      assign mask_w[b] = '0;
      assign pend_w[b] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) prio_q[i] <= '0;
    end else if (wipe) begin
      for (int i = 0; i < NUM_LINES; i++) prio_q[i] <= '0;
    end else if (wr && prio_ok) begin
      prio_q[prio_idx[LINE_W-1:0]] <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_flat
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  irqc_prio_pick #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_pick (
    .pend_i (pend_all),
    .prio_i (prio_flat),
    .win_o  (win)
  );

  // sorted-line latch, released only by acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      line_q <= '0;
    end else if (wipe) begin
      held_q <= 1'b0;
      line_q <= '0;
    end else if (held_q) begin
      if (ack) held_q <= 1'b0;
    end else if (win.valid) begin
      held_q <= 1'b1;
      line_q <= win.line;
    end
  end

  assign irq_o = held_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == OFF_REV)       bus_rdata_o = {24'b0, REV};
    else if (bus_addr_i == OFF_CFG)  bus_rdata_o = {30'b0, busy, 1'b0};
    else if (bus_addr_i == OFF_STAT) bus_rdata_o = {31'b0, ~busy};
    else if (bus_addr_i == OFF_SORT) bus_rdata_o = held_q ? {25'b0, line_q} : 32'h0000_00FF;
    else if (bank_hit) begin
      if (bank_off == BOFF_MASK)      bus_rdata_o = mask_w[bank_sel];
      else if (bank_off == BOFF_PEND) bus_rdata_o = pend_w[bank_sel];
    end else if (prio_ok) begin
      bus_rdata_o = 32'(prio_q[prio_idx[LINE_W-1:0]]);
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_en_i,
  input logic        bus_we_i,
  input logic [9:0]  bus_addr_i,
  input logic [31:0] bus_wdata_i,
  input logic        irq_o,
  input logic        busy_i,
  input logic [31:0] mask0_i
);
  logic wr_c, ack_c, soft_c;
  assign wr_c   = bus_en_i & bus_we_i;
  assign ack_c  = wr_c && bus_addr_i == 10'h048 && bus_wdata_i[0];
  assign soft_c = wr_c && bus_addr_i == 10'h010 && bus_wdata_i[1];

  a_r3_set_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && bus_addr_i == 10'h08C && !busy_i) |=>
      ((mask0_i & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  a_r4_clr_unmasks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && bus_addr_i == 10'h088 && !busy_i) |=>
      ((mask0_i & $past(bus_wdata_i)) == 32'h0));

  a_r8_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_c && !soft_c) |=> irq_o);

  a_r9_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_c |=> !irq_o);

  a_r10_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !irq_o);

  a_r10_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_c && !busy_i) |=> busy_i);
endmodule

bind irqc_top irqc_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_en_i    (bus_en_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .busy_i      (busy),
  .mask0_i     (mask_all[31:0])
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  localparam int NL  = 128;
  localparam int RST = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] src = '0;
  logic          en = 1'b0, we = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  int            checks = 0, fails = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  irqc_top #(.NUM_LINES(NL), .PRIO_W(6), .RST_CYC(RST), .REV(8'h21)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  bit m_mask[NL];
  int m_prio[NL];
  bit m_held;
  int m_line;
  int m_cnt;

  function automatic void m_clear();
    for (int i = 0; i < NL; i++) begin m_mask[i] = 1; m_prio[i] = 0; end
    m_held = 0; m_line = 0;
  endfunction

  function automatic void m_pick(output bit v, output int l);
    int best;
    v = 0; l = 0; best = 1000;
    for (int i = 0; i < NL; i++)
      if (src[i] && !m_mask[i] && m_prio[i] < best) begin v = 1; l = i; best = m_prio[i]; end
  endfunction

  function automatic logic [31:0] m_read(int a);
    logic [31:0] r;
    int b, off;
    r = 0;
    if (a == 'h00) r = 32'h21;
    else if (a == 'h10) r = (m_cnt != 0) ? 32'h2 : 32'h0;
    else if (a == 'h14) r = (m_cnt != 0) ? 32'h0 : 32'h1;
    else if (a == 'h40) r = m_held ? 32'(m_line) : 32'hFF;
    else if (a >= 'h80 && a < 'h100) begin
      b = (a - 'h80) / 32; off = (a - 'h80) % 32;
      for (int i = 0; i < 32; i++) begin
        if (off == 4)  r[i] = m_mask[b*32+i];
        if (off == 24) r[i] = src[b*32+i] & !m_mask[b*32+i];
      end
    end else if (a >= 'h100 && a % 4 == 0 && (a - 'h100) / 4 < NL) r = 32'(m_prio[(a - 'h100) / 4]);
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_clear(); m_cnt = 0;
    end else begin : upd
      bit w, sw, ack, v;
      int l, a, b, off, idx;
      a = int'(addr);
      w = en && we;
      sw = w && a == 'h10 && wdata[1];
      if (sw || m_cnt != 0) begin
        m_clear();
        if (m_cnt != 0) m_cnt--; else m_cnt = RST;
      end else begin
        m_pick(v, l);
        ack = w && a == 'h48 && wdata[0];
        if (m_held) begin
          if (ack) m_held = 0;
        end else if (v) begin
          m_held = 1; m_line = l;
        end
        if (w && a >= 'h80 && a < 'h100) begin
          b = (a - 'h80) / 32; off = (a - 'h80) % 32;
          for (int i = 0; i < 32; i++)
            if (wdata[i]) begin
              if (off == 12) m_mask[b*32+i] = 1;
              else if (off == 8) m_mask[b*32+i] = 0;
            end
        end
        if (w && a >= 'h100 && a % 4 == 0) begin
          idx = (a - 'h100) / 4;
          if (idx < NL) m_prio[idx] = int'(wdata[5:0]);
        end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // R8: irq_o against the model on every clock
  always @(negedge clk) if (rst_n && !done) check("R8 irq_o", {31'b0, irq}, {31'b0, m_held});

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); en = 1; we = 1; addr = 10'(a); wdata = d;
    @(negedge clk); en = 0; we = 0;
  endtask

  task automatic rd(string tag, int a);
    @(negedge clk); en = 1; we = 0; addr = 10'(a);
    #1 check(tag, rdata, m_read(a));
    en = 0;
  endtask

  task automatic set_src(logic [NL-1:0] v);
    @(negedge clk); src = v;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [NL-1:0] v;
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd("R2 revision", 'h00);
    for (int b = 0; b < 4; b++) rd("R1 mask after reset", 'h84 + 32*b);
    rd("R1 sorted spurious", 'h40);
    rd("R1 status done", 'h14);
    rd("R1 prio zero", 'h100 + 4*77);

    v = '0; v[5] = 1; v[40] = 1; v[70] = 1; v[100] = 1;
    set_src(v);
    rd("R5 masked pend b0", 'h98);
    wr('h88, 32'h1 << 5);
    rd("R4 mask cleared b0", 'h84);
    rd("R5 pend b0", 'h98);
    rd("R8 sorted line 5", 'h40);

    wr('h100 + 4*5, 9);
    wr('h100 + 4*40, 3);
    wr('h100 + 4*70, 3);
    wr('h100 + 4*100, 1);
    rd("R6 prio 40", 'h100 + 4*40);
    rd("R6 prio 100", 'h100 + 4*100);
    wr('hA8, 32'h1 << 8);
    wr('hC8, 32'h1 << 6);
    wr('hE8, 32'h1 << 4);
    rd("R8 sorted holds 5", 'h40);
    wr('h48, 0);
    rd("R9 no-ack write", 'h40);
    wr('h48, 1);
    rd("R7 lowest prio 100", 'h40);
    wr('hEC, 32'h1 << 4);
    rd("R3 mask set b3", 'hE4);
    wr('h48, 1);
    rd("R7 tie lower index 40", 'h40);
    v[40] = 0;
    set_src(v);
    rd("R8 sorted holds after drop", 'h40);
    rd("R5 pend drops b1", 'hB8);
    wr('h48, 1);
    rd("R8 next winner 70", 'h40);
    wr('h8C, 32'h0);
    rd("R3 zero bits unchanged", 'h84);

    wr('h10, 32'h2);
    rd("R10 cfg busy", 'h10);
    rd("R10 status busy", 'h14);
    wr('h88, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    rd("R10 status done", 'h14);
    rd("R10 mask restored", 'h84);
    rd("R10 prio cleared", 'h100 + 4*100);
    rd("R10 sorted cleared", 'h40);

    for (int b = 0; b < 4; b++) wr('h88 + 32*b, 32'hFFFF_FFFF);
    for (int i = 0; i < NL; i++) wr('h100 + 4*i, 32'((i * 37) % 64));
    s = 32'h1234_5678;
    for (int k = 0; k < 40; k++) begin
      for (int q = 0; q < 4; q++) begin
        s = s * 32'd1664525 + 32'd1013904223;
        v[q*32 +: 32] = s & (s >> 7) & (s >> 13);
      end
      set_src(v);
      rd("R7 sorted pattern", 'h40);
      rd("R5 pend pattern", 'h98 + 32*(k % 4));
      wr('h48, 1);
      rd("R9 after ack", 'h40);
    end
    finish_run();
  end
endmodule